// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked request port and an external asynchronous static RAM of 65,536 sixteen-bit words. Each host request carries a direction flag, a word address, write data and a two-bit lane mask. The controller turns the request into a timed sequence of active-low strobes: chip select, write strobe, output enable and one select per byte lane. It also drives the address bus and the split data bus, which is an output value, a drive enable and a sampled input.

Every transaction runs through four steps: idle, a one-cycle setup, an active phase and a one-cycle hold. The length of the active phase in clock cycles comes from nanosecond limits given as parameters. For a write, the limit is the largest of the write-pulse width, the data setup to the end of the write, and the address setup to the end of the write. For a read, it is the largest of the address-to-data, output-enable-to-data and lane-select-to-data delays. Each count is rounded up and is never less than one. The host sees ready drop while a transaction is in flight. A read ends with a single-cycle response that carries the word, with any unselected lane returned as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, req_ready is 1. mem_ce_n, mem_we_n, mem_oe_n and both bits of mem_lane_n are 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: An accepted write gives one setup cycle (mem_ce_n 0, mem_we_n 1, bus not driven). Then mem_we_n is 0 for WR_CYC cycles, where WR_CYC = max(1, ceil(max(T_WE_PULSE_NS, T_DATA_SETUP_NS, T_ADDR_TO_END_NS) / CLK_PERIOD_NS)). Then comes one hold cycle with mem_ce_n and mem_we_n both 1.
- R3: mem_dq_oe is 1 exactly in the cycles where mem_we_n is 0. During those cycles mem_dq_out carries the request's write data.
- R4: Mask bit 0 selects the low lane (mem_lane_n[0], data bits 7:0) and mask bit 1 selects the high lane (mem_lane_n[1], data bits 15:8). A lane select is low through the setup, active and hold cycles only when its mask bit is 1. A write changes only the selected lanes.
- R5: An accepted read gives one setup cycle. Then mem_ce_n and mem_oe_n are 0 with mem_we_n 1 for RD_CYC cycles, where RD_CYC = max(1, ceil(max(T_READ_ACCESS_NS, T_OE_DATA_NS, T_LANE_DATA_NS) / CLK_PERIOD_NS)). mem_dq_in is sampled at the end of the last of those cycles.
- R6: A read raises rsp_valid for exactly one cycle, the cycle right after the last output-enable cycle. rsp_rdata holds the sampled lanes, and any lane whose mask bit is 0 reads as zero.
- R7: req_ready is 0 from the cycle after acceptance until the hold cycle ends. A request held valid while busy is taken only once ready returns.
- R8: A write never raises rsp_valid.
- R9: With mask 00, no lane select goes low. A write then leaves memory unchanged and a read returns 0x0000.
- R10: mem_addr equals the request address and stays stable from the setup cycle through the hold cycle.
- R11: mem_we_n and mem_oe_n are never both 0, and mem_ce_n is 0 whenever either of them is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 16 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Lane selects, active low, bit 0 low byte |
| mem_dq_out | output | 16 | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Sampled data bus |

## Verification
The bench runs with a clock period that makes the write phase two cycles and the read phase three. An off-by-one in the phase counter would therefore show up as a wrong strobe length, or as data sampled before the bus model drives it. Single-lane writes and single-lane reads go after lane swaps and leaks: a swapped lane would corrupt the other byte, and a missing zero mask would return the bus model's filler pattern. A mask of 00 and a request held valid through a busy transaction target a controller that strobes with no lane selected or that accepts a request twice. A high address and a hold-cycle probe catch an address that changes before the write strobe has risen.

// File: rtl/srl_pkg.sv
package srl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ACT   = 2'd2,
    ST_HOLD  = 2'd3
  } srl_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // ceil(ns / period) with a floor of one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/srl_rst_sync.sv
module srl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/srl_phase_timer.sv
module srl_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/srl_lane_capture.sv
module srl_lane_capture #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic [LANES-1:0]   lane_en,
  input  logic [LANES*8-1:0] bus_in,
  output logic [LANES*8-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q, byte_d;

    always_comb begin
      byte_d = byte_q;
      if (cap_en) byte_d = lane_en[g] ? bus_in[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= 8'h00;
      else        byte_q <= byte_d;
    end

    assign rdata[g*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import srl_pkg::*;
#(
  parameter int ADDR_W            = 16,
  parameter int DATA_W            = 16,
  parameter int CLK_PERIOD_NS     = 10,
  parameter int T_WE_PULSE_NS     = 8,
  parameter int T_DATA_SETUP_NS   = 6,
  parameter int T_ADDR_TO_END_NS  = 7,
  parameter int T_READ_ACCESS_NS  = 10,
  parameter int T_OE_DATA_NS      = 4,
  parameter int T_LANE_DATA_NS    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_lane_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in
);
  localparam int LANES  = DATA_W / 8;
  localparam int WR_CYC = ns_to_cyc(max3(T_WE_PULSE_NS, T_DATA_SETUP_NS, T_ADDR_TO_END_NS),
                                    CLK_PERIOD_NS);
  localparam int RD_CYC = ns_to_cyc(max3(T_READ_ACCESS_NS, T_OE_DATA_NS, T_LANE_DATA_NS),
                                    CLK_PERIOD_NS);
  localparam int MAX_CYC = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic rst_n_s;

  srl_rst_sync u_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  // ---------------- sequencer state ----------------
  srl_state_e state_q, state_d;
  logic       accept;
  logic       tmr_last;
  logic       tmr_load;
  logic       cap_en;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic              wr_q;
  logic [LANES-1:0]  mask_sel;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mask_sel  = accept ? req_mask : mask_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)   state_d = ST_SETUP;
      ST_SETUP:               state_d = ST_ACT;
      ST_ACT:   if (tmr_last) state_d = ST_HOLD;
      ST_HOLD:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
      wr_q    <= req_write;
    end
  end

  // ---------------- phase timer ----------------
  assign tmr_load = (state_q == ST_SETUP);

  srl_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (tmr_load),
    .load_val(wr_q ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC)),
    .last    (tmr_last)
  );

  // ---------------- strobe registers ----------------
  logic             ce_n_d, we_n_d, oe_n_d, dq_oe_d;
  logic [LANES-1:0] lane_n_d;
  logic             ce_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [LANES-1:0] lane_n_q;

  always_comb begin
    ce_n_d   = !((state_d == ST_SETUP) || (state_d == ST_ACT));
    we_n_d   = !((state_d == ST_ACT) && wr_q);
    oe_n_d   = !((state_d == ST_ACT) && !wr_q);
    dq_oe_d  = (state_d == ST_ACT) && wr_q;
    lane_n_d = (state_d == ST_IDLE) ? {LANES{1'b1}} : ~mask_sel;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ce_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      lane_n_q <= {LANES{1'b1}};
    end else begin
      ce_n_q   <= ce_n_d;
      we_n_q   <= we_n_d;
      oe_n_q   <= oe_n_d;
      dq_oe_q  <= dq_oe_d;
      lane_n_q <= lane_n_d;
    end
  end

  assign mem_ce_n   = ce_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_dq_oe  = dq_oe_q;
  assign mem_lane_n = lane_n_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  // ---------------- read return ----------------
  logic rvalid_q;

  assign cap_en = (state_q == ST_ACT) && tmr_last && !wr_q;

  srl_lane_capture #(.LANES(LANES)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .cap_en (cap_en),
    .lane_en(mask_q),
    .bus_in (mem_dq_in),
    .rdata  (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rvalid_q <= 1'b0;
    else          rvalid_q <= cap_en;
  end

  assign rsp_valid = rvalid_q;
endmodule

// File: rtl/srl_checker.sv
module srl_checker #(
  parameter int ADDR_W = 16,
  parameter int WR_CYC = 1,
  parameter int RD_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  logic [31:0] we_run, oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? 32'd0 : we_run + 32'd1;
      oe_run <= mem_oe_n ? 32'd0 : oe_run + 32'd1;
    end
  end

  assert_we_oe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_ce_covers_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);

  assert_drive_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe == !mem_we_n);

  assert_we_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == WR_CYC));

  assert_oe_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == RD_CYC));

  assert_rsp_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl srl_checker #(
  .ADDR_W(ADDR_W),
  .WR_CYC(WR_CYC),
  .RD_CYC(RD_CYC)
) u_srl_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DUT_PER_NS = 4;
  localparam int EXP_WR     = 2;   // ceil(max(8,6,7)/4)
  localparam int EXP_RD     = 3;   // ceil(max(10,4,5)/4)

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(.CLK_PERIOD_NS(DUT_PER_NS)) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- memory model (low 8 address bits) ----------------
  logic [15:0] ram [0:255];

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lane_n[0]) ram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_lane_n[1]) ram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  always_comb begin
    mem_dq_in = 16'hDEAD;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      mem_dq_in[7:0]  = mem_lane_n[0] ? 8'h5A : ram[mem_addr[7:0]][7:0];
      mem_dq_in[15:8] = mem_lane_n[1] ? 8'h5A : ram[mem_addr[7:0]][15:8];
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int          n_we, n_oe, n_busy, n_rv, e_drive, e_addr, e_lane, e_excl;
  logic [15:0] rd;
  logic        setup_ok, hold_ok;

  task automatic run_txn(input logic w, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] m);
    logic prev_act;
    n_we = 0; n_oe = 0; n_busy = 0; n_rv = 0;
    e_drive = 0; e_addr = 0; e_lane = 0; e_excl = 0;
    rd = 16'h0; setup_ok = 1'b0; hold_ok = 1'b0; prev_act = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    setup_ok = !mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe;
    for (int i = 0; i < 60; i++) begin
      if (req_ready) break;
      n_busy++;
      if (!mem_we_n) n_we++;
      if (!mem_oe_n) n_oe++;
      if (mem_dq_oe != !mem_we_n) e_drive++;
      if (!mem_we_n && mem_dq_out != d) e_drive++;
      if (!mem_we_n && !mem_oe_n) e_excl++;
      if (mem_addr != a) e_addr++;
      if (mem_lane_n != ~m) e_lane++;
      if (rsp_valid) begin n_rv++; rd = rsp_rdata; end
      if (prev_act && mem_we_n && mem_oe_n)
        hold_ok = mem_ce_n && (mem_addr == a) && (mem_lane_n == ~m);
      prev_act = !mem_we_n || !mem_oe_n;
      @(negedge clk);
    end
    if (rsp_valid) n_rv++;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    for (int i = 0; i < 256; i++) ram[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_lane_n}, 5'b11111);
    chk("R1 bus released in reset", {mem_dq_oe, rsp_valid}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);
  endtask

  task automatic t_write_full();
    run_txn(1'b1, 16'h0012, 16'hBEEF, 2'b11);
    chk("R2 setup cycle", setup_ok, 1);
    chk("R2 write pulse cycles", n_we, EXP_WR);
    chk("R2 hold cycle", hold_ok, 1);
    chk("R7 busy cycles write", n_busy, EXP_WR + 2);
    chk("R3 drive window", e_drive, 0);
    chk("R8 no response on write", n_rv, 0);
    chk("R11 we/oe exclusive", e_excl + n_oe, 0);
    chk("R4 lanes during write", e_lane, 0);
    chk("R4 full word stored", ram[8'h12], 16'hBEEF);
  endtask

  task automatic t_read_full();
    run_txn(1'b0, 16'h0012, 16'h0000, 2'b11);
    chk("R5 oe cycles", n_oe, EXP_RD);
    chk("R5 no write strobe on read", n_we, 0);
    chk("R6 single response", n_rv, 1);
    chk("R6 read data", rd, 16'hBEEF);
    chk("R7 busy cycles read", n_busy, EXP_RD + 2);
    chk("R10 address stable read", e_addr, 0);
  endtask

  task automatic t_byte_writes();
    run_txn(1'b1, 16'h0012, 16'h1177, 2'b01);
    chk("R4 low lane only", ram[8'h12], 16'hBE77);
    chk("R4 low lane select", e_lane, 0);
    run_txn(1'b1, 16'h0012, 16'h2288, 2'b10);
    chk("R4 high lane only", ram[8'h12], 16'h2277);
    run_txn(1'b0, 16'h0012, 16'h0000, 2'b11);
    chk("R4 merged readback", rd, 16'h2277);
  endtask

  task automatic t_lane_reads();
    run_txn(1'b0, 16'h0012, 16'h0000, 2'b10);
    chk("R6 high lane read, low zero", rd, 16'h2200);
    run_txn(1'b0, 16'h0012, 16'h0000, 2'b01);
    chk("R6 low lane read, high zero", rd, 16'h0077);
  endtask

  task automatic t_mask_none();
    run_txn(1'b1, 16'h0012, 16'hFFFF, 2'b00);
    chk("R9 no lane select on empty write", e_lane, 0);
    chk("R9 memory unchanged", ram[8'h12], 16'h2277);
    run_txn(1'b0, 16'h0012, 16'h0000, 2'b00);
    chk("R9 empty read returns zero", rd, 16'h0000);
    chk("R9 empty read still responds", n_rv, 1);
  endtask

  task automatic t_high_addr();
    run_txn(1'b1, 16'hFF34, 16'hC0DE, 2'b11);
    chk("R10 address through write", e_addr, 0);
    chk("R10 hold keeps address", hold_ok, 1);
    chk("R10 stored at addressed word", ram[8'h34], 16'hC0DE);
  endtask

  task automatic t_busy_hold();
    int acc = 0;
    int we_edges = 0;
    logic prev_we = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_mask = 2'b11;
    req_addr = 16'h0021; req_wdata = 16'hAAAA;
    for (int i = 0; i < 40; i++) begin
      if (req_valid && req_ready) begin
        acc++;
        @(negedge clk);
        if (acc == 1) begin req_addr = 16'h0022; req_wdata = 16'h5555; end
        else req_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
      if (prev_we && !mem_we_n) we_edges++;
      prev_we = mem_we_n;
    end
    req_valid = 1'b0;
    chk("R7 two accepts while held", acc, 2);
    chk("R7 two write pulses", we_edges, 2);
    chk("R7 first word", ram[8'h21], 16'hAAAA);
    chk("R7 second word", ram[8'h22], 16'h5555);
  endtask

  // ---------------- sequencing and watchdog ----------------
  initial begin
    t_reset();
    t_write_full();
    t_read_full();
    t_byte_writes();
    t_lane_reads();
    t_mask_none();
    t_high_addr();
    t_busy_hold();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule